// File: doc/BRIEF.md
# Branch Target Predicting Fetch Address Unit

This block owns the fetch program counter and chooses, every cycle, the address the front end fetches next. Alongside the instruction-cache access it looks up the current fetch address in a small direct-mapped table of branch targets. If the address hits an entry whose direction bit says "taken", the stored target becomes the next fetch address. In every other case the sequential address, the current address plus the fetch size, is used.

Resolved branches come back through a resolve port. Only a branch that was actually taken creates or rewrites an entry, and it stores the target with the direction bit set. A not-taken outcome that hits an existing entry only clears that entry's direction bit, so each entry predicts the direction its branch took the last time it ran. A redirect input from branch resolution has priority over the prediction and sets the next fetch address in the same cycle.

Top module: `btb_fetch_predictor`

## Requirements
- R1: While reset is asserted and until the first clock edge after it, `fetch_pc` equals `RESET_PC`. All entries start invalid, so every lookup after reset misses (`pred_hit`=0).
- R2: When the lookup hits and the entry's direction bit is 1, `pred_hit`=1, `pred_taken`=1 and `next_pc` is the stored target, provided no redirect is present.
- R3: When the lookup misses and no redirect is present, `next_pc` = `fetch_pc` + 4.
- R4: When the lookup hits an entry whose direction bit is 0, `pred_hit`=1, `pred_taken`=0 and `next_pc` = `fetch_pc` + 4.
- R5: A resolve with `res_taken`=0 whose PC has no matching entry allocates nothing, so a later lookup of that PC misses.
- R6: A resolve with `res_taken`=1 writes the tag, the target and a set direction bit into the entry at the PC's index. A lookup of that PC in any later cycle hits and predicts the target.
- R7: A resolve with `res_taken`=0 that hits an entry clears only its direction bit. The entry stays valid, so a later lookup reports a hit that is predicted not taken.
- R8: The index is PC bits [5:2] and the tag is PC bits [31:6]. A PC with the same index but a different tag misses.
- R9: When `redir_valid`=1, `next_pc` = `redir_addr` in that same cycle, whatever the prediction is.
- R10: When a resolve writes the entry that the current lookup reads in the same cycle, the lookup uses the contents the entry held before that write.
- R11: On every clock edge after reset, `fetch_pc` takes the value `next_pc` had just before that edge.
- R12: A not-taken resolve whose tag differs from the tag stored at its index leaves that entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Redirect request from branch resolution |
| redir_addr | input | 32 | Redirect fetch address |
| res_valid | input | 1 | Resolved branch report present |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |
| res_target | input | 32 | Actual target of the resolved branch |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Address to fetch in the next cycle |
| pred_hit | output | 1 | Lookup of `fetch_pc` hit a valid entry |
| pred_taken | output | 1 | Hit entry predicts taken |

## Verification
A lookup and a resolve can fall in the same cycle and address the same entry. The bench provokes this by steering `fetch_pc` onto a branch with a redirect and driving a resolve for that branch in the cycle the lookup happens. It does this both for allocating a fresh entry and for clearing the direction bit of an existing one. It judges `next_pc` in that cycle against the entry's old contents, then revisits the PC to confirm that the write took effect. Redirect against a live taken prediction is the other collision, and there `next_pc` must follow the redirect.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Source that produced the next fetch address
  typedef enum logic [1:0] {
    NPC_SEQ   = 2'd0,
    NPC_PRED  = 2'd1,
    NPC_REDIR = 2'd2
  } npc_src_e;

  // Kind of table write requested by a resolved branch
  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_ALLOC   = 2'd1,
    WR_DIR_CLR = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup read port
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [ADDR_W-1:0] lk_target,
  output logic              lk_dir,
  // resolve read port
  input  logic [IDX_W-1:0]  rs_idx,
  output logic              rs_valid,
  output logic [TAG_W-1:0]  rs_tag,
  // write port
  input  btb_pkg::wr_kind_e wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic              wr_dir
);
  import btb_pkg::*;

  logic              valid_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  logic [ADDR_W-1:0] target_q [ENTRIES];
  logic              dir_q    [ENTRIES];

  logic [ENTRIES-1:0] full_we;
  logic [ENTRIES-1:0] dir_we;

  // write enable decode
  always_comb begin
    full_we = '0;
    dir_we  = '0;
    if (wr_kind == WR_ALLOC) begin
      full_we[wr_idx] = 1'b1;
      dir_we[wr_idx]  = 1'b1;
    end else if (wr_kind == WR_DIR_CLR) begin
      dir_we[wr_idx] = 1'b1;
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q[e] <= 1'b0;
        end else if (full_we[e]) begin
          valid_q[e] <= 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (full_we[e]) begin
          tag_q[e]    <= wr_tag;
          target_q[e] <= wr_target;
        end
      end

      always_ff @(posedge clk) begin
        if (dir_we[e]) begin
          dir_q[e] <= wr_dir;
        end
      end
    end
  endgenerate

  // read ports return registered contents (old data on a same-cycle write)
  always_comb begin
    lk_valid  = valid_q[lk_idx];
    lk_tag    = tag_q[lk_idx];
    lk_target = target_q[lk_idx];
    lk_dir    = dir_q[lk_idx];
    rs_valid  = valid_q[rs_idx];
    rs_tag    = tag_q[rs_idx];
  end

endmodule

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
  parameter int TAG_W = 26
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] pc_tag,
  output logic             hit
);
  always_comb begin
    hit = ent_valid && (ent_tag == pc_tag);
  end
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26
) (
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_hit,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [ADDR_W-1:0] res_target,
  output btb_pkg::wr_kind_e wr_kind,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] wr_target,
  output logic              wr_dir
);
  import btb_pkg::*;

  always_comb begin
    wr_idx    = res_idx;
    wr_tag    = res_tag;
    wr_target = res_target;
    wr_dir    = res_taken;
    wr_kind   = WR_NONE;
    if (res_valid) begin
      if (res_taken) begin
        wr_kind = WR_ALLOC;
      end else if (res_hit) begin
        wr_kind = WR_DIR_CLR;
      end
    end
  end
endmodule

// File: rtl/btb_npc_select.sv
module btb_npc_select #(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = 4
) (
  input  logic              [ADDR_W-1:0] pc,
  input  logic                           hit,
  input  logic                           dir,
  input  logic              [ADDR_W-1:0] target,
  input  logic                           redir_valid,
  input  logic              [ADDR_W-1:0] redir_addr,
  output logic                           taken,
  output btb_pkg::npc_src_e              src,
  output logic              [ADDR_W-1:0] next_pc
);
  import btb_pkg::*;

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FETCH_BYTES);

  always_comb begin
    taken = hit && dir;
    if (redir_valid) begin
      src = NPC_REDIR;
    end else if (taken) begin
      src = NPC_PRED;
    end else begin
      src = NPC_SEQ;
    end
    case (src)
      NPC_REDIR: next_pc = redir_addr;
      NPC_PRED:  next_pc = target;
      default:   next_pc = pc + STEP;
    endcase
  end
endmodule

// File: rtl/btb_fetch_predictor.sv
module btb_fetch_predictor #(
  parameter int              ADDR_W      = 32,
  parameter int              ENTRIES     = 16,
  parameter int              FETCH_BYTES = 4,
  parameter logic [31:0]     RESET_PC    = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_hit,
  output logic              pred_taken
);
  import btb_pkg::*;

  localparam int OFS_W = $clog2(FETCH_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;
  localparam int TAG_LSB = IDX_W + OFS_W;

  logic [ADDR_W-1:0] pc_q, pc_d;

  logic [IDX_W-1:0]  lk_idx, rs_idx;
  logic [TAG_W-1:0]  lk_pc_tag, rs_pc_tag;
  logic              lk_valid, rs_valid;
  logic [TAG_W-1:0]  lk_tag, rs_tag;
  logic [ADDR_W-1:0] lk_target;
  logic              lk_dir;
  logic              lk_hit, rs_hit;

  wr_kind_e          wr_kind;
  logic [IDX_W-1:0]  wr_idx;
  logic [TAG_W-1:0]  wr_tag;
  logic [ADDR_W-1:0] wr_target;
  logic              wr_dir;
  npc_src_e          npc_src;
  logic              npc_taken;

  // address fields
  always_comb begin
    lk_idx    = pc_q[TAG_LSB-1:OFS_W];
    lk_pc_tag = pc_q[ADDR_W-1:TAG_LSB];
    rs_idx    = res_pc[TAG_LSB-1:OFS_W];
    rs_pc_tag = res_pc[ADDR_W-1:TAG_LSB];
  end

  btb_store #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (lk_idx),
    .lk_valid  (lk_valid),
    .lk_tag    (lk_tag),
    .lk_target (lk_target),
    .lk_dir    (lk_dir),
    .rs_idx    (rs_idx),
    .rs_valid  (rs_valid),
    .rs_tag    (rs_tag),
    .wr_kind   (wr_kind),
    .wr_idx    (wr_idx),
    .wr_tag    (wr_tag),
    .wr_target (wr_target),
    .wr_dir    (wr_dir)
  );

  btb_tag_match #(.TAG_W(TAG_W)) u_lk_match (
    .ent_valid (lk_valid),
    .ent_tag   (lk_tag),
    .pc_tag    (lk_pc_tag),
    .hit       (lk_hit)
  );

  btb_tag_match #(.TAG_W(TAG_W)) u_rs_match (
    .ent_valid (rs_valid),
    .ent_tag   (rs_tag),
    .pc_tag    (rs_pc_tag),
    .hit       (rs_hit)
  );

  btb_update_ctl #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_update (
    .res_valid  (res_valid),
    .res_taken  (res_taken),
    .res_hit    (rs_hit),
    .res_idx    (rs_idx),
    .res_tag    (rs_pc_tag),
    .res_target (res_target),
    .wr_kind    (wr_kind),
    .wr_idx     (wr_idx),
    .wr_tag     (wr_tag),
    .wr_target  (wr_target),
    .wr_dir     (wr_dir)
  );

  btb_npc_select #(
    .ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES)
  ) u_npc (
    .pc          (pc_q),
    .hit         (lk_hit),
    .dir         (lk_dir),
    .target      (lk_target),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .taken       (npc_taken),
    .src         (npc_src),
    .next_pc     (pc_d)
  );

  // fetch PC register, loads every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= ADDR_W'(RESET_PC);
    end else begin
      pc_q <= pc_d;
    end
  end

  always_comb begin
    fetch_pc   = pc_q;
    next_pc    = pc_d;
    pred_hit   = lk_hit;
    pred_taken = npc_taken && (npc_src != NPC_SEQ);
  end

endmodule

// File: rtl/btb_fetch_predictor_chk.sv
module btb_fetch_predictor_chk #(
  parameter int ADDR_W      = 32,
  parameter int FETCH_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_pc,
  input logic              res_taken,
  input logic [ADDR_W-1:0] res_target,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] next_pc,
  input logic              pred_hit,
  input logic              pred_taken
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FETCH_BYTES);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  // R9
  redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> next_pc == redir_addr);

  // R3
  miss_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !pred_hit) |-> next_pc == fetch_pc + STEP);

  // R4
  hit_not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && pred_hit && !pred_taken) |-> next_pc == fetch_pc + STEP);

  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  // R11
  pc_follows_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> fetch_pc == $past(next_pc));

  // R6
  alloc_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |=> (fetch_pc != $past(res_pc)) ||
      (pred_taken && (redir_valid || next_pc == $past(res_target))));

endmodule

bind btb_fetch_predictor btb_fetch_predictor_chk #(
  .ADDR_W(ADDR_W), .FETCH_BYTES(FETCH_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .redir_valid (redir_valid),
  .redir_addr  (redir_addr),
  .res_valid   (res_valid),
  .res_pc      (res_pc),
  .res_taken   (res_taken),
  .res_target  (res_target),
  .fetch_pc    (fetch_pc),
  .next_pc     (next_pc),
  .pred_hit    (pred_hit),
  .pred_taken  (pred_taken)
);

// File: tb/btb_fetch_predictor_bench.sv
module btb_fetch_predictor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [31:0] redir_addr = '0;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic [31:0] fetch_pc, next_pc;
  logic        pred_hit, pred_taken;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  btb_fetch_predictor #(.RESET_PC(32'h0000_1000)) u_btb_fetch_predictor (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target),
    .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // put fetch_pc on addr; returns at the negedge where fetch_pc==addr
  task automatic goto(input logic [31:0] addr);
    @(negedge clk);
    redir_valid = 1'b1;
    redir_addr  = addr;
    @(negedge clk);
    redir_valid = 1'b0;
    #1;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #20;
    chk("R1 pc in reset", fetch_pc, 32'h1000);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 pc after release", fetch_pc, 32'h1000);
    chk("R1 miss after reset", {31'b0, pred_hit}, 32'h0);
    chk("R3 seq after reset", next_pc, 32'h1004);
    for (int i = 0; i < 16; i++) begin
      goto(32'h0000_8000 + 32'(i * 4));
      chk("R1 entry invalid", {31'b0, pred_hit}, 32'h0);
    end
  endtask

  task automatic t_alloc;
    resolve(32'h2008, 1'b1, 32'h4000);
    goto(32'h2008);
    chk("R6 hit after alloc", {30'b0, pred_hit, pred_taken}, 32'h3);
    chk("R2 target used", next_pc, 32'h4000);
    @(negedge clk); #1;
    chk("R11 pc loads target", fetch_pc, 32'h4000);
    chk("R3 seq on miss", next_pc, 32'h4004);
  endtask

  task automatic t_nt_noalloc;
    resolve(32'h3010, 1'b0, 32'h9000);
    goto(32'h3010);
    chk("R5 no alloc on not-taken", {31'b0, pred_hit}, 32'h0);
    chk("R5 seq next", next_pc, 32'h3014);
  endtask

  task automatic t_alias;
    goto(32'h2048);
    chk("R8 tag mismatch miss", {31'b0, pred_hit}, 32'h0);
    chk("R8 seq next", next_pc, 32'h204C);
  endtask

  task automatic t_nt_clear;
    resolve(32'h2008, 1'b0, 32'h0);
    goto(32'h2008);
    chk("R7 still valid", {31'b0, pred_hit}, 32'h1);
    chk("R4 predicted not taken", {31'b0, pred_taken}, 32'h0);
    chk("R4 seq next", next_pc, 32'h200C);
    resolve(32'h2008, 1'b1, 32'h5000);
    goto(32'h2008);
    chk("R6 rewrite target", next_pc, 32'h5000);
  endtask

  task automatic t_nt_other_tag;
    resolve(32'h2048, 1'b0, 32'h0);
    goto(32'h2008);
    chk("R12 entry untouched", {30'b0, pred_hit, pred_taken}, 32'h3);
    chk("R12 target kept", next_pc, 32'h5000);
  endtask

  task automatic t_redirect;
    goto(32'h2008);
    redir_valid = 1'b1;
    redir_addr  = 32'h7000;
    #1;
    chk("R9 redirect beats prediction", next_pc, 32'h7000);
    @(negedge clk);
    redir_valid = 1'b0;
    #1;
    chk("R9 pc took redirect", fetch_pc, 32'h7000);
  endtask

  task automatic t_same_cycle;
    // fresh allocation while lookup reads the same entry
    goto(32'h2100);
    res_valid = 1'b1; res_pc = 32'h2100; res_taken = 1'b1; res_target = 32'h6000;
    #1;
    chk("R10 lookup sees old (empty)", next_pc, 32'h2104);
    @(negedge clk);
    res_valid = 1'b0;
    goto(32'h2100);
    chk("R10 write landed", next_pc, 32'h6000);
    // direction clear while lookup reads the same entry
    goto(32'h2008);
    res_valid = 1'b1; res_pc = 32'h2008; res_taken = 1'b0; res_target = 32'h0;
    #1;
    chk("R10 lookup sees old taken", next_pc, 32'h5000);
    @(negedge clk);
    res_valid = 1'b0;
    goto(32'h2008);
    chk("R10 clear landed", {30'b0, pred_hit, pred_taken}, 32'h2);
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_nt_noalloc();
    t_alias();
    t_nt_clear();
    t_nt_other_tag();
    t_redirect();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule